// File: doc/BRIEF.md
# Signalling-Channel C/I Change Detector

This block sits on the line side of a serial frame of byte-wide time slots. Every four slots form one serial channel: two data slots, one monitor slot, and one signalling slot. The signalling slot carries, in transmit order, two D bits, a 4-bit command/indication (C/I) field, and two handshake bits (MR, MX). A per-slot control memory holds a 4-bit code for each direction. Code `4'h0` means the slot is not handled. Code `4'h5` means the slot gets signalling preprocessing.

For an upstream signalling slot with code `4'h5`, the block takes the C/I field and compares it with the value it stored for that channel. When the value changes, it writes the slot address into a 16-entry queue and raises an interrupt. A host reads the queue to find which layer-1 devices changed state. For a downstream signalling slot with code `4'h5`, the block drives the C/I value written by the host. It releases the D bit positions so that an external D-channel controller can drive them. It either forces MR/MX to 1 (no-handshake option) or releases them.

Timing comes from a phase machine with states HUNT, OTHER, DBIT, CI and HS. HUNT holds until the first frame sync and then moves to OTHER. While locked, each bit moves through OTHER→DBIT→CI→HS→OTHER, and a frame sync returns it to OTHER. The CI→HS transition is the compare event: the captured field is checked, and it may be queued.

Top module: `ci_change_detector`

## Requirements
- R1: `fsync` high marks slot 0 bit 0, and each following clock is the next bit, wrapping after 256 bits. Until the first `fsync` (phase HUNT), `dn_oe` stays low and nothing is queued.
- R2: Channel n uses slot 4n+3 for signalling. Within a slot, bit 0 is the MSB, sent first. Bits 0–1 are D, bits 2–5 are C/I (MSB first), bit 6 is MR and bit 7 is MX.
- R3: Reset or a `cm_clr` pulse sets every code in both directions to `4'h0` (unassigned). An unassigned upstream slot never queues a report, and an unassigned downstream slot keeps `dn_oe` low.
- R4: Upstream codes (`cm_dir`=0) and downstream codes (`cm_dir`=1) are stored separately per slot. Code `4'h5` selects signalling preprocessing.
- R5: When an upstream slot with code `4'h5` receives a C/I value that differs from the stored one, its 5-bit slot address is queued at the clock edge that ends bit 6 of that slot.
- R6: Stored C/I values reset to 0. The first compare after any write to a channel's upstream signalling code, or after `cm_clr`, only stores the value and queues nothing.
- R7: Upstream D bits never cause a report. Downstream D positions keep `dn_oe` low.
- R8: With `hs_off`=1, MR and MX are driven as 1. With `hs_off`=0, those positions keep `dn_oe` low.
- R9: Downstream C/I bits carry the value last written by `ci_we`/`ci_chan`/`ci_val`, MSB first.
- R10: The queue holds 16 addresses, and `fifo_addr` shows the oldest one. `fifo_pop` removes it. A pop on an empty queue is ignored.
- R11: A report that arrives while 16 entries are held is dropped and sets `fifo_ovf`, which stays set until reset.
- R12: `irq` is high exactly while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bit clock |
| rst_n | input | 1 | asynchronous active-low reset |
| fsync | input | 1 | frame start, high during slot 0 bit 0 |
| up_din | input | 1 | upstream serial data |
| dn_dout | output | 1 | downstream serial data |
| dn_oe | output | 1 | downstream drive enable (0 = high impedance) |
| hs_off | input | 1 | 1 = no-handshake option, MR/MX forced to 1 |
| cm_we | input | 1 | control memory write strobe |
| cm_dir | input | 1 | 0 = upstream code, 1 = downstream code |
| cm_slot | input | 5 | slot written |
| cm_code | input | 4 | code written |
| cm_clr | input | 1 | clear all codes to unassigned |
| ci_we | input | 1 | downstream C/I write strobe |
| ci_chan | input | 3 | channel for downstream C/I |
| ci_val | input | 4 | downstream C/I value |
| fifo_pop | input | 1 | remove the oldest queued address |
| fifo_addr | output | 5 | oldest queued slot address |
| fifo_empty | output | 1 | queue empty |
| fifo_full | output | 1 | queue holds 16 entries |
| fifo_ovf | output | 1 | sticky overflow flag |
| irq | output | 1 | change interrupt |

## Verification
The phase-order and hunt checks assume that, once locked, `fsync` arrives only on a 256-bit boundary or not at all. The stimulus therefore sends back-to-back frames from a single generator. The compare event assumes the host does not rewrite a channel's upstream code in the same cycle as that channel's compare. The stimulus does its control memory writes in the first slots of a frame, well before the first signalling slot. The bench model handles pops that coincide with pushes itself, so those are left free.

// File: rtl/ci_pkg.sv
package ci_pkg;
    typedef enum logic [2:0] {
        PH_HUNT,
        PH_OTHER,
        PH_DBIT,
        PH_CI,
        PH_HS
    } phase_e;

    localparam int CI_W   = 4;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_UNASSIGNED = 4'h0;
    localparam logic [CODE_W-1:0] CODE_SIG        = 4'h5;
endpackage

// File: rtl/ci_frame_timer.sv
module ci_frame_timer
    import ci_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int POS_W = $clog2(SLOTS * 8),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [2:0]        cur_bit,
    output phase_e            phase_d,
    output phase_e            phase_q
);
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] cur_pos;
    logic             synced_q;
    logic             valid;

    assign valid    = synced_q | fsync;
    assign cur_pos  = fsync ? '0 : pos_q + 1'b1;
    assign cur_slot = cur_pos[POS_W-1:3];
    assign cur_bit  = cur_pos[2:0];

    always_comb begin
        if (!valid)                      phase_d = PH_HUNT;
        else if (cur_slot[1:0] != 2'b11) phase_d = PH_OTHER;
        else if (cur_bit < 3'd2)         phase_d = PH_DBIT;
        else if (cur_bit < 3'd6)         phase_d = PH_CI;
        else                             phase_d = PH_HS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= PH_HUNT;
            synced_q <= 1'b0;
            pos_q    <= '0;
        end else begin
            phase_q  <= phase_d;
            synced_q <= valid;
            if (valid) pos_q <= cur_pos;
        end
    end

    assert_dbit_then_ci_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DBIT && !fsync) |-> (phase_d == PH_DBIT || phase_d == PH_CI));
    assert_ci_then_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CI && !fsync) |-> (phase_d == PH_CI || phase_d == PH_HS));
endmodule

// File: rtl/ci_ctrl_mem.sv
module ci_ctrl_mem
    import ci_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic              wr_dir,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [CODE_W-1:0] rd_up,
    output logic [CODE_W-1:0] rd_dn
);
    logic [CODE_W-1:0] rd_code [2];

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic [CODE_W-1:0] code_q [SLOTS];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < SLOTS; i++) code_q[i] <= CODE_UNASSIGNED;
            end else if (clr) begin
                for (int i = 0; i < SLOTS; i++) code_q[i] <= CODE_UNASSIGNED;
            end else if (we && wr_dir == 1'(d)) begin
                code_q[wr_slot] <= wr_code;
            end
        end
        assign rd_code[d] = code_q[rd_slot];
    end

    assign rd_up = rd_code[0];
    assign rd_dn = rd_code[1];
endmodule

// File: rtl/ci_addr_fifo.sv
module ci_addr_fifo #(
    parameter int DEPTH = 16,
    parameter int W = 5,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         ovf
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (cnt_q != CW'(DEPTH));
    assign pop_ok  = pop && (cnt_q != '0);
    assign head    = mem_q[rd_q];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wr_q <= bump(wr_q);
            if (pop_ok)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok) ovf <= 1'b1;
        end
    end

    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    assert_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/ci_change_detector.sv
module ci_change_detector
    import ci_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int FIFO_DEPTH = 16,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int NCH = SLOTS / 4,
    localparam int CH_W = SLOT_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              up_din,
    output logic              dn_dout,
    output logic              dn_oe,
    input  logic              hs_off,
    input  logic              cm_we,
    input  logic              cm_dir,
    input  logic [SLOT_W-1:0] cm_slot,
    input  logic [CODE_W-1:0] cm_code,
    input  logic              cm_clr,
    input  logic              ci_we,
    input  logic [CH_W-1:0]   ci_chan,
    input  logic [CI_W-1:0]   ci_val,
    input  logic              fifo_pop,
    output logic [SLOT_W-1:0] fifo_addr,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_ovf,
    output logic              irq
);
    phase_e            phase_d, phase_q;
    logic [SLOT_W-1:0] cur_slot;
    logic [2:0]        cur_bit;
    logic [CH_W-1:0]   cur_ch;
    logic [CODE_W-1:0] up_code, dn_code;
    logic [CI_W-1:0]   ci_sh;
    logic [CI_W-1:0]   stored_q [NCH];
    logic [CI_W-1:0]   tx_q [NCH];
    logic [NCH-1:0]    primed_q;
    logic              compare, push;
    logic [1:0]        ci_idx;

    ci_frame_timer #(.SLOTS(SLOTS)) u_timer (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .cur_slot(cur_slot), .cur_bit(cur_bit),
        .phase_d(phase_d), .phase_q(phase_q)
    );

    ci_ctrl_mem #(.SLOTS(SLOTS)) u_cm (
        .clk(clk), .rst_n(rst_n), .clr(cm_clr), .we(cm_we), .wr_dir(cm_dir),
        .wr_slot(cm_slot), .wr_code(cm_code), .rd_slot(cur_slot),
        .rd_up(up_code), .rd_dn(dn_code)
    );

    assign cur_ch  = cur_slot[SLOT_W-1:2];
    assign compare = (phase_q == PH_CI) && (phase_d == PH_HS) && (up_code == CODE_SIG);
    assign push    = compare && primed_q[cur_ch] && (ci_sh != stored_q[cur_ch]);
    assign ci_idx  = 2'(3'd5 - cur_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ci_sh    <= '0;
            primed_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                stored_q[i] <= '0;
                tx_q[i]     <= '0;
            end
        end else begin
            if (phase_d == PH_CI) ci_sh <= {ci_sh[CI_W-2:0], up_din};
            if (compare) begin
                stored_q[cur_ch] <= ci_sh;
                primed_q[cur_ch] <= 1'b1;
            end
            if (cm_clr) primed_q <= '0;
            else if (cm_we && !cm_dir && cm_slot[1:0] == 2'b11)
                primed_q[cm_slot[SLOT_W-1:2]] <= 1'b0;
            if (ci_we) tx_q[ci_chan] <= ci_val;
        end
    end

    always_comb begin
        dn_oe   = 1'b0;
        dn_dout = 1'b0;
        unique case (phase_d)
            PH_HUNT, PH_OTHER, PH_DBIT: begin
                dn_oe = 1'b0;
            end
            PH_CI: begin
                dn_oe   = (dn_code == CODE_SIG);
                dn_dout = tx_q[cur_ch][ci_idx];
            end
            PH_HS: begin
                dn_oe   = (dn_code == CODE_SIG) && hs_off;
                dn_dout = 1'b1;
            end
            default: dn_oe = 1'b0;
        endcase
    end

    ci_addr_fifo #(.DEPTH(FIFO_DEPTH), .W(SLOT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(cur_slot),
        .pop(fifo_pop), .head(fifo_addr), .empty(fifo_empty),
        .full(fifo_full), .ovf(fifo_ovf)
    );

    assign irq = !fifo_empty;

    assert_hunt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_d == PH_HUNT) |-> (!dn_oe && !push));
    assert_unassigned_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_code == CODE_UNASSIGNED) |-> !dn_oe);
    assert_dbit_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_d == PH_DBIT) |-> !dn_oe);
    assert_push_needs_sig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (up_code == CODE_SIG && phase_q == PH_CI));
endmodule

// File: tb/ci_change_detector_bench.sv
`timescale 1ns/1ps
module ci_change_detector_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0, up_din = 1'b0, hs_off = 1'b0;
    logic cm_we = 1'b0, cm_dir = 1'b0, cm_clr = 1'b0;
    logic [4:0] cm_slot = '0;
    logic [3:0] cm_code = '0;
    logic ci_we = 1'b0;
    logic [2:0] ci_chan = '0;
    logic [3:0] ci_val = '0;
    logic fifo_pop = 1'b0;
    logic dn_dout, dn_oe, fifo_empty, fifo_full, fifo_ovf, irq;
    logic [4:0] fifo_addr;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    ci_change_detector u_ci_change_detector (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .up_din(up_din),
        .dn_dout(dn_dout), .dn_oe(dn_oe), .hs_off(hs_off),
        .cm_we(cm_we), .cm_dir(cm_dir), .cm_slot(cm_slot), .cm_code(cm_code),
        .cm_clr(cm_clr), .ci_we(ci_we), .ci_chan(ci_chan), .ci_val(ci_val),
        .fifo_pop(fifo_pop), .fifo_addr(fifo_addr), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_ovf(fifo_ovf), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model
    bit m_sync = 0;
    int m_pos = 0, m_acc = 0;
    int m_up[32], m_dn[32], m_sto[8], m_tx[8];
    bit m_pri[8];
    int q[$];
    bit m_ovf = 0;

    always @(negedge clk) begin
        #4;
        begin
            bit valid, push, ok_pop;
            int cur, slot, b, sz, exp_oe, exp_d;
            valid = m_sync || fsync;
            cur = fsync ? 0 : (m_pos + 1) % 256;
            slot = cur / 8; b = cur % 8;
            exp_oe = 0; exp_d = 0;
            if (rst_n && valid && slot % 4 == 3 && m_dn[slot] == 5) begin
                if (b >= 2 && b <= 5) begin exp_oe = 1; exp_d = (m_tx[slot/4] >> (5 - b)) & 1; end
                else if (b >= 6 && hs_off) begin exp_oe = 1; exp_d = 1; end
            end
            chk(dn_oe == exp_oe, "R2/R3/R7/R8", "dn_oe", dn_oe, exp_oe);
            if (exp_oe == 1) chk(dn_dout == exp_d, "R9/R8", "dn_dout", dn_dout, exp_d);
            chk(fifo_empty == (q.size() == 0), "R10", "fifo_empty", fifo_empty, q.size() == 0);
            chk(fifo_full == (q.size() == 16), "R10", "fifo_full", fifo_full, q.size() == 16);
            chk(irq == (q.size() != 0), "R12", "irq", irq, q.size() != 0);
            chk(fifo_ovf == m_ovf, "R11", "fifo_ovf", fifo_ovf, m_ovf);
            if (q.size() > 0) chk(fifo_addr == q[0], "R5", "fifo_addr", fifo_addr, q[0]);
            if (!rst_n) begin
                m_sync = 0; m_pos = 0; m_acc = 0; m_ovf = 0; q.delete();
                for (int i = 0; i < 32; i++) begin m_up[i] = 0; m_dn[i] = 0; end
                for (int i = 0; i < 8; i++) begin m_sto[i] = 0; m_tx[i] = 0; m_pri[i] = 0; end
            end else begin
                push = 0;
                if (valid && slot % 4 == 3) begin
                    if (b >= 2 && b <= 5) m_acc = ((m_acc << 1) | up_din) & 15;
                    if (b == 6 && m_up[slot] == 5) begin
                        if (!m_pri[slot/4]) m_pri[slot/4] = 1;
                        else if (m_acc != m_sto[slot/4]) push = 1;
                        m_sto[slot/4] = m_acc;
                    end
                end
                sz = q.size();
                ok_pop = fifo_pop && sz > 0;
                if (ok_pop) void'(q.pop_front());
                if (push) begin
                    if (sz < 16) q.push_back(slot);
                    else m_ovf = 1;
                end
                if (cm_clr) begin
                    for (int i = 0; i < 32; i++) begin m_up[i] = 0; m_dn[i] = 0; end
                    for (int i = 0; i < 8; i++) m_pri[i] = 0;
                end else if (cm_we) begin
                    if (cm_dir) m_dn[cm_slot] = cm_code;
                    else begin
                        m_up[cm_slot] = cm_code;
                        if (cm_slot % 4 == 3) m_pri[cm_slot/4] = 0;
                    end
                end
                if (ci_we) m_tx[ci_chan] = ci_val;
                m_sync = valid;
                if (valid) m_pos = cur;
            end
        end
    end

    // frame generator
    logic [7:0] ub [32];
    logic [7:0] cur_ub [32];
    bit stream_on = 0;
    event frame_done;

    initial begin
        wait (stream_on);
        forever begin
            for (int i = 0; i < 256; i++) begin
                @(negedge clk);
                if (i == 0) cur_ub = ub;
                fsync = (i == 0);
                up_din = cur_ub[i/8][7 - (i % 8)];
            end
            ->frame_done;
        end
    end

    function automatic logic [7:0] sig(input logic [1:0] d, input logic [3:0] c);
        return {d, c, 2'b11};
    endfunction

    task automatic cm_write(input bit dir, input int slot, input int code);
        @(negedge clk);
        cm_we = 1; cm_dir = dir; cm_slot = 5'(slot); cm_code = 4'(code);
        @(negedge clk);
        cm_we = 0;
    endtask

    task automatic ci_write(input int ch, input int v);
        @(negedge clk);
        ci_we = 1; ci_chan = 3'(ch); ci_val = 4'(v);
        @(negedge clk);
        ci_we = 0;
    endtask

    task automatic pop_check(input int exp, input string req);
        @(negedge clk); #4;
        chk(!fifo_empty && fifo_addr == 5'(exp), req, "queued address", fifo_addr, exp);
        @(negedge clk); fifo_pop = 1;
        @(negedge clk); fifo_pop = 0;
    endtask

    task automatic all_ci(input int v);
        for (int c = 0; c < 8; c++) ub[4*c+3] = sig(2'b00, 4'(v));
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < 32; s++) ub[s] = (s % 4 == 3) ? sig(2'b00, 4'h0) : 8'($urandom);
        repeat (5) @(negedge clk);
        #4;
        chk(!dn_oe && fifo_empty && !irq && !fifo_full && !fifo_ovf, "R3", "reset state", dn_oe, 0);
        rst_n = 1;
        repeat (20) begin @(negedge clk); up_din = 1'($urandom); end
        #4;
        chk(fifo_empty && !dn_oe, "R1", "no activity before fsync", fifo_empty, 1);
        stream_on = 1;
        @(frame_done);
        // frame 1: configure, prime
        ub[3] = sig(2'b00, 4'h5); ub[7] = sig(2'b00, 4'h0);
        ub[11] = sig(2'b00, 4'h0); ub[15] = sig(2'b00, 4'h9);
        hs_off = 1;
        cm_write(0, 3, 5); cm_write(0, 7, 5); cm_write(0, 11, 5);
        cm_write(1, 3, 5); cm_write(1, 7, 5);
        ci_write(0, 4'hA); ci_write(1, 4'h3);
        @(frame_done);
        #4;
        chk(fifo_empty, "R6", "first frame after config reports nothing", fifo_empty, 1);
        // frame 2: one change, D-only change, unassigned change
        ub[7] = sig(2'b00, 4'h7); ub[11] = sig(2'b10, 4'h0); ub[15] = sig(2'b00, 4'h4);
        @(frame_done);
        #4;
        chk(fifo_addr == 5'd7 && !fifo_empty, "R5", "change on channel 1", fifo_addr, 7);
        chk(irq == 1, "R12", "irq while queued", irq, 1);
        // frame 3: two changes
        ub[3] = sig(2'b00, 4'h6); ub[11] = sig(2'b10, 4'hF);
        @(frame_done);
        #4;
        chk(!fifo_full, "R7", "D-only change not queued", fifo_full, 0);
        pop_check(7, "R10"); pop_check(3, "R10"); pop_check(11, "R10");
        @(negedge clk); fifo_pop = 1;
        @(negedge clk); fifo_pop = 0; #4;
        chk(fifo_empty && !fifo_ovf, "R10", "pop on empty ignored", fifo_empty, 1);
        @(frame_done);
        // frame 4: handshake option, new downstream value
        hs_off = 0;
        ci_write(1, 4'hC);
        @(frame_done);
        // frame 5: all channels preprocessed, prime
        all_ci(0);
        for (int c = 0; c < 8; c++) cm_write(0, 4*c+3, 5);
        @(frame_done);
        #4;
        chk(fifo_empty, "R6", "reconfigured channels prime", fifo_empty, 1);
        all_ci(15);
        @(frame_done);
        all_ci(0);
        @(frame_done);
        #4;
        chk(fifo_full && !fifo_ovf, "R10", "queue full at 16", fifo_full, 1);
        all_ci(15);
        @(frame_done);
        #4;
        chk(fifo_ovf == 1, "R11", "overflow flag set", fifo_ovf, 1);
        for (int k = 0; k < 16; k++) pop_check((k % 8) * 4 + 3, "R11");
        #1;
        chk(fifo_ovf == 1 && fifo_empty, "R11", "overflow sticky after drain", fifo_ovf, 1);
        @(frame_done);
        // frame 10: control memory clear
        all_ci(5);
        @(negedge clk); cm_clr = 1;
        @(negedge clk); cm_clr = 0;
        @(frame_done);
        #4;
        chk(fifo_empty, "R3", "cleared codes report nothing", fifo_empty, 1);
        chk(!dn_oe, "R4", "downstream released after clear", dn_oe, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule